// File: doc/BRIEF.md
# Serial Flash Identification Responder

This block is the part of a serial flash slave that answers identity queries from a bus master. It watches chip select, the serial clock and the serial data input. It recognises two commands. The first returns a fixed three-byte identity. The second takes an address argument and then returns the manufacturer and device codes, one after the other, in an order set by that argument. All other opcodes leave the output idle until the next selection.

The serial pins are brought into the block's own clock domain through short synchroniser chains. The block uses SPI mode 0: the clock idles low, input bits are captured on the rising SCLK edge, and output bits change on the falling edge. The output pin is modelled as a data bit and an enable. The pad logic around the block turns this pair into a high-impedance pin.

A busy signal from the write engine blocks the three-byte identity command while a program or erase is running. The running write is never affected.

Top module: `serial_id_responder`

## Requirements
- R1: After reset, and whenever chip select is high, `so_en` is 0.
- R2: Opcode 9Fh, sent MSB first, is answered with the bytes C2h, 24h, 15h in that order. Each byte is MSB first, and each bit changes on a falling SCLK edge.
- R3: If the master keeps clocking after the third identity byte, the stream starts again at C2h.
- R4: Opcode 90h is followed by two padding bytes, whose values are ignored, and then an address byte. Address 00h makes the manufacturer code C2h come first.
- R5: Address 01h makes the device code (14h by default) come first.
- R6: After the first code, the manufacturer and device codes keep alternating for as long as SCLK runs.
- R7: If `busy` is 1 when opcode 9Fh completes, the command is not decoded, and `so_en` stays 0 for the rest of that selection.
- R8: Raising chip select ends any command, even in the middle of a byte. The next selection decodes a fresh opcode.
- R9: `so_en` is 0 during the opcode, padding and address bytes, and for the whole selection after an opcode that is not recognised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; it must be several times faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select from the master, active low |
| sclk | input | 1 | Serial clock from the master, idle low |
| si | input | 1 | Serial data from the master |
| busy | input | 1 | High while the write engine runs a program or erase |
| so_d | output | 1 | Serial output data bit |
| so_en | output | 1 | Drive enable for the serial output pin |

## Verification
The bench builds the block with the manufacturer, memory-type, density and device codes set to C2h, 24h, 15h and 14h, with two padding bytes and two synchroniser stages. Because every code byte differs from the others, each ordering case has its own expected sequence. These cases are the identity wrap after three bytes, the start code chosen by address 00h or 01h, and the alternation over four bytes. With two padding bytes, the bench can also show that non-zero padding values are ignored. The SCLK half period is six block clocks. This leaves room for the two synchroniser stages and the output register before the master samples the data.

// File: rtl/serial_id_responder.sv
module serial_id_responder #(
  parameter logic [7:0] OP_JEDEC    = 8'h9F,
  parameter logic [7:0] OP_MFRDEV   = 8'h90,
  parameter logic [7:0] MFR_ID      = 8'hC2,
  parameter logic [7:0] MEM_TYPE    = 8'h24,
  parameter logic [7:0] DENSITY     = 8'h15,
  parameter logic [7:0] DEV_ID      = 8'h14,
  parameter int         PAD_BYTES   = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic si,
  input  logic busy,
  output logic so_d,
  output logic so_en
);

  localparam int AW = $clog2(PAD_BYTES + 1);

  typedef enum logic [2:0] {S_CMD, S_ARG, S_JID, S_MD, S_IGN} state_t;

  logic [SYNC_STAGES-1:0] sck_sr, cs_sr, si_sr;
  logic                   sck_prev;
  logic [6:0]             sh;
  logic [2:0]             bitcnt;
  logic [AW-1:0]          argcnt;
  logic [1:0]             idx;
  logic                   sel;
  state_t                 st;
  logic [7:0]             cur_byte;

  wire sck     = sck_sr[SYNC_STAGES-1];
  wire cs      = cs_sr[SYNC_STAGES-1];
  wire si_s    = si_sr[SYNC_STAGES-1];
  wire rise    = sck & ~sck_prev & ~cs;
  wire fall    = ~sck & sck_prev & ~cs;
  wire [7:0] byte_in = {sh, si_s};
  wire byte_done = rise && (bitcnt == 3'd7);

  always_comb begin
    case (st)
      S_JID:   cur_byte = (idx == 2'd0) ? MFR_ID : (idx == 2'd1) ? MEM_TYPE : DENSITY;
      S_MD:    cur_byte = sel ? DEV_ID : MFR_ID;
      default: cur_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr   <= '0;
      cs_sr    <= '1;
      si_sr    <= '0;
      sck_prev <= 1'b0;
      sh       <= '0;
      bitcnt   <= '0;
      argcnt   <= '0;
      idx      <= '0;
      sel      <= 1'b0;
      st       <= S_CMD;
      so_d     <= 1'b0;
      so_en    <= 1'b0;
    end else begin
      sck_sr   <= {sck_sr[SYNC_STAGES-2:0], sclk};
      cs_sr    <= {cs_sr[SYNC_STAGES-2:0], cs_n};
      si_sr    <= {si_sr[SYNC_STAGES-2:0], si};
      sck_prev <= sck;
      if (cs) begin
        st     <= S_CMD;
        bitcnt <= '0;
        argcnt <= '0;
        idx    <= '0;
        sel    <= 1'b0;
        so_d   <= 1'b0;
        so_en  <= 1'b0;
      end else begin
        if (rise) begin
          sh     <= byte_in[6:0];
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          case (st)
            S_CMD: begin
              if (byte_in == OP_JEDEC && !busy) st <= S_JID;
              else if (byte_in == OP_MFRDEV)    st <= S_ARG;
              else                              st <= S_IGN;
            end
            S_ARG: begin
              if (argcnt == AW'(PAD_BYTES)) begin
                sel <= byte_in[0];
                st  <= S_MD;
              end else begin
                argcnt <= argcnt + AW'(1);
              end
            end
            S_JID:   idx <= (idx == 2'd2) ? 2'd0 : idx + 2'd1;
            S_MD:    sel <= ~sel;
            default: ;
          endcase
        end
        if (fall && (st == S_JID || st == S_MD)) begin
          so_d  <= cur_byte[~bitcnt];
          so_en <= 1'b1;
        end
      end
    end
  end

  a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs |=> !so_en);

  a_r9_quiet_outside_data: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD || st == S_ARG || st == S_IGN) |-> !so_en);

  a_r7_busy_blocks_jedec: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !cs && st == S_CMD && busy) |=> st != S_JID);

  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx != 2'd3);

  a_r2_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_en) |-> $past(fall));

endmodule

// File: tb/sim_serial_id_responder.sv
module sim_serial_id_responder;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, si = 1'b0, busy = 1'b0;
  logic so_d, so_en;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_id_responder #(.MFR_ID(8'hC2), .MEM_TYPE(8'h24), .DENSITY(8'h15),
                        .DEV_ID(8'h14), .PAD_BYTES(2), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si), .busy(busy),
    .so_d(so_d), .so_en(so_en));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_seen);
    oe_seen = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      half_wait();
      rx[i] = so_d;
      if (so_en) oe_seen = 1'b1;
      sclk = 1'b1;
      half_wait();
      sclk = 1'b0;
    end
  endtask

  task automatic select();
    cs_n = 1'b0;
    half_wait();
  endtask

  task automatic deselect();
    half_wait();
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset oe", {7'd0, so_en}, 8'h00);
  endtask

  task automatic t_jedec();
    logic [7:0] rx; logic oe;
    logic [7:0] exp [4] = '{8'hC2, 8'h24, 8'h15, 8'hC2};
    select();
    xfer(8'h9F, rx, oe);
    check("R9 oe during opcode", {7'd0, oe}, 8'h00);
    for (int b = 0; b < 4; b++) begin
      xfer(8'h00, rx, oe);
      check(b < 3 ? "R2 identity byte" : "R3 identity wrap", rx, exp[b]);
      check("R2 oe during data", {7'd0, oe}, 8'h01);
    end
    deselect();
    check("R1 oe after deselect", {7'd0, so_en}, 8'h00);
  endtask

  task automatic t_mfrdev(input logic [7:0] addr, input logic [7:0] p0, input logic [7:0] p1);
    logic [7:0] rx; logic oe; logic any_oe;
    logic [7:0] first, second;
    first  = addr[0] ? 8'h14 : 8'hC2;
    second = addr[0] ? 8'hC2 : 8'h14;
    select();
    any_oe = 1'b0;
    xfer(8'h90, rx, oe); any_oe |= oe;
    xfer(p0, rx, oe);    any_oe |= oe;
    xfer(p1, rx, oe);    any_oe |= oe;
    xfer(addr, rx, oe);  any_oe |= oe;
    check("R9 oe during opcode/pad/address", {7'd0, any_oe}, 8'h00);
    for (int b = 0; b < 4; b++) begin
      xfer(8'h00, rx, oe);
      if (b == 0) check(addr[0] ? "R5 device first" : "R4 manufacturer first", rx, first);
      else        check("R6 alternation", rx, (b % 2 == 0) ? first : second);
    end
    deselect();
  endtask

  task automatic t_busy();
    logic [7:0] rx; logic oe; logic any_oe;
    busy = 1'b1;
    select();
    xfer(8'h9F, rx, oe);
    any_oe = 1'b0;
    for (int b = 0; b < 3; b++) begin
      xfer(8'h00, rx, oe);
      any_oe |= oe;
    end
    check("R7 busy blocks identity", {7'd0, any_oe}, 8'h00);
    check("R7 oe at end", {7'd0, so_en}, 8'h00);
    deselect();
    busy = 1'b0;
  endtask

  task automatic t_abort();
    logic [7:0] rx; logic oe;
    select();
    xfer(8'h9F, rx, oe);
    xfer(8'h00, rx, oe);
    check("R8 first byte before abort", rx, 8'hC2);
    for (int i = 0; i < 3; i++) begin
      half_wait(); sclk = 1'b1; half_wait(); sclk = 1'b0;
    end
    deselect();
    check("R8 oe after abort", {7'd0, so_en}, 8'h00);
    select();
    xfer(8'h90, rx, oe);
    xfer(8'h00, rx, oe);
    xfer(8'h00, rx, oe);
    xfer(8'h01, rx, oe);
    xfer(8'h00, rx, oe);
    check("R8 fresh decode after abort", rx, 8'h14);
    deselect();
  endtask

  task automatic t_unknown();
    logic [7:0] rx; logic oe; logic any_oe;
    select();
    xfer(8'h03, rx, oe);
    any_oe = oe;
    for (int b = 0; b < 3; b++) begin
      xfer(8'h00, rx, oe);
      any_oe |= oe;
    end
    check("R9 unknown opcode silent", {7'd0, any_oe}, 8'h00);
    deselect();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_jedec();
    t_mfrdev(8'h00, 8'hAA, 8'h55);
    t_mfrdev(8'h01, 8'hFF, 8'h3C);
    t_busy();
    t_jedec();
    t_abort();
    t_unknown();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule